// File: doc/BRIEF.md
# Multiplexed Handshake Bus Register Target

This block is the responding end of a narrow, asynchronous, multiplexed bus. One 8-bit lane carries, in turn, a register address and up to two data bytes. Every transfer is a four-phase handshake: the master raises a ready strobe, and this target answers on an acknowledge line. The master's strobe, its two byte-lane enables and its direction line reach the target with no clock relation to it. The target samples them through synchronizer flops and runs a clocked state machine that decodes each phase.

Behind the bus sits a small bank of 16-bit registers. Bytes are numbered so that each word starts at an even byte address, with the high byte first. An address phase latches the byte address. Each later phase moves one byte into or out of the word that holds that address, and the lane enable picks the half. On reads the target drives the shared lane through a separate output and output-enable pair, meant for a pad-level tristate buffer. It turns that enable off before it ends the handshake. Every register word is also brought out as a flat vector so that other logic can watch it.

Top module: `hsbus_regfile`

## Requirements
- R1: A synchronous reset, applied at any time, leaves ack_o low, ad_oe_o low and every register word zero on the clock edge that samples it.
- R2: A phase with rdy_i high and both lane enables low, with an address of 0 to 5 on ad_i, is acknowledged. ack_o then stays high for as long as rdy_i stays high, and goes low after rdy_i returns low.
- R3: An address of 6 or more is never acknowledged. The data phases that follow it, until the next accepted address, are not acknowledged either and change no register.
- R4: In a write (rd_i low), a phase with only hbe_i high stores ad_i into bits [15:8] of the addressed word, and a phase with only lbe_i high stores it into bits [7:0]. The other byte of the word is left unchanged, and ack_o rises only after the store.
- R5: In a read (rd_i high), a phase with only hbe_i high (or only lbe_i high) puts bits [15:8] (or bits [7:0]) of the addressed word on ad_o, with ad_oe_o high, no later than the edge at which ack_o rises.
- R6: At the end of a read phase, ad_oe_o falls at least one cycle before ack_o falls. ad_oe_o is never high during an address phase or a write phase.
- R7: A data phase with hbe_i and lbe_i both high is not acknowledged and changes no register.
- R8: Word k of the bank appears on regs_o[16k+15:16k].
- R9: Byte addresses 2k and 2k+1 both select word k, and the lane enable alone picks the byte. An odd address therefore reaches the same word as the even address below it.
- R10: ack_o changes only in response to synchronized inputs: it rises only when rdy_i was high two cycles earlier, and it falls only when rdy_i was low two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_i | input | 1 | Master ready strobe, asynchronous |
| hbe_i | input | 1 | High-byte lane enable, asynchronous |
| lbe_i | input | 1 | Low-byte lane enable, asynchronous |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| ad_i | input | 8 | Address/data lane as received from the pad |
| ad_o | output | 8 | Read byte to drive onto the lane |
| ad_oe_o | output | 1 | Lane output enable; low means high impedance |
| ack_o | output | 1 | Acknowledge to the master |
| regs_o | output | 48 | All register words, word k at [16k+15:16k] |

## Verification
The assertions assume that the master follows the four-phase rules. It sets the lane enables, the direction and the lane value before it raises rdy_i, and it holds them until ack_o has fallen. It never raises rdy_i again before it has seen ack_o low. Under these rules the two-cycle timing checks on ack_o are valid. The bench's master task sets up each phase one cycle before it raises the strobe, and waits for every acknowledge to fall before it changes anything. On an unanswered phase it drops the strobe and idles long enough for the target to return to idle.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_DRIVE,
    ST_DRIVE_ACK,
    ST_RELEASE,
    ST_MUTE
  } hsb_state_t;
endpackage

// File: rtl/hsb_sync.sv
module hsb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsb_regbank.sv
module hsb_regbank #(
  parameter int NREG = 3,
  parameter int BW   = 8,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               we_hi,
  input  logic [IW-1:0]      widx,
  input  logic [BW-1:0]      wdata,
  input  logic [IW-1:0]      ridx,
  output logic [2*BW-1:0]    rword,
  output logic [NREG*2*BW-1:0] flat
);
  localparam int WW = 2 * BW;

  logic [WW-1:0] mem [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[k] <= '0;
      end else if (we && (int'(widx) == k)) begin
        if (we_hi) mem[k][WW-1:BW] <= wdata;
        else       mem[k][BW-1:0]  <= wdata;
      end
    end
    assign flat[k*WW +: WW] = mem[k];
  end

  always_comb begin
    rword = '0;
    for (int k = 0; k < NREG; k++)
      if (int'(ridx) == k) rword = mem[k];
  end
endmodule

// File: rtl/hsb_fsm.sv
module hsb_fsm
  import hsb_pkg::*;
#(
  parameter int BW    = 8,
  parameter int NBYTE = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_rdy,
  input  logic          s_hbe,
  input  logic          s_lbe,
  input  logic          s_rd,
  input  logic [BW-1:0] ad_in,
  input  logic [2*BW-1:0] rword,
  output logic          ack,
  output logic          oe,
  output logic [BW-1:0] ad_out,
  output logic [BW-1:0] addr_q,
  output logic          we,
  output logic          we_hi,
  output logic [BW-1:0] wdata
);
  hsb_state_t st;
  logic       addr_ok;
  logic       is_addr, one_lane, in_range;

  assign is_addr  = !s_hbe && !s_lbe;
  assign one_lane = s_hbe ^ s_lbe;
  assign in_range = int'(ad_in) < NBYTE;

  // write strobe to the bank: issued in the cycle the phase is accepted
  assign we    = (st == ST_IDLE) && s_rdy && one_lane && addr_ok && !s_rd;
  assign we_hi = s_hbe;
  assign wdata = ad_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      ack     <= 1'b0;
      oe      <= 1'b0;
      ad_out  <= '0;
      addr_q  <= '0;
      addr_ok <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (s_rdy) begin
          if (is_addr) begin
            if (in_range) begin
              addr_q  <= ad_in;
              addr_ok <= 1'b1;
              ack     <= 1'b1;
              st      <= ST_HOLD;
            end else begin
              addr_ok <= 1'b0;
              st      <= ST_MUTE;
            end
          end else if (!one_lane || !addr_ok) begin
            st <= ST_MUTE;
          end else if (s_rd) begin
            ad_out <= s_hbe ? rword[2*BW-1:BW] : rword[BW-1:0];
            oe     <= 1'b1;
            st     <= ST_DRIVE;
          end else begin
            ack <= 1'b1;
            st  <= ST_HOLD;
          end
        end
        ST_DRIVE: begin
          ack <= 1'b1;
          st  <= ST_DRIVE_ACK;
        end
        ST_DRIVE_ACK: if (!s_rdy) begin
          oe <= 1'b0;
          st <= ST_RELEASE;
        end
        ST_RELEASE: begin
          ack <= 1'b0;
          st  <= ST_IDLE;
        end
        ST_HOLD: if (!s_rdy) begin
          ack <= 1'b0;
          st  <= ST_IDLE;
        end
        ST_MUTE: if (!s_rdy) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hsbus_regfile.sv
module hsbus_regfile #(
  parameter int NREG   = 3,
  parameter int BW     = 8,
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rdy_i,
  input  logic                  hbe_i,
  input  logic                  lbe_i,
  input  logic                  rd_i,
  input  logic [BW-1:0]         ad_i,
  output logic [BW-1:0]         ad_o,
  output logic                  ad_oe_o,
  output logic                  ack_o,
  output logic [NREG*2*BW-1:0]  regs_o
);
  localparam int NBYTE = 2 * NREG;
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1;

  logic [3:0]      s_ctl;
  logic [BW-1:0]   addr_q;
  logic [2*BW-1:0] rword;
  logic            we, we_hi;
  logic [BW-1:0]   wdata;
  logic [IW-1:0]   widx;

  hsb_sync #(.W(4), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({rdy_i, hbe_i, lbe_i, rd_i}),
    .q(s_ctl)
  );

  hsb_fsm #(.BW(BW), .NBYTE(NBYTE)) u_fsm (
    .clk(clk), .rst(rst),
    .s_rdy(s_ctl[3]), .s_hbe(s_ctl[2]), .s_lbe(s_ctl[1]), .s_rd(s_ctl[0]),
    .ad_in(ad_i), .rword(rword),
    .ack(ack_o), .oe(ad_oe_o), .ad_out(ad_o), .addr_q(addr_q),
    .we(we), .we_hi(we_hi), .wdata(wdata)
  );

  // word index: byte address with bit 0 dropped
  assign widx = addr_q[IW:1];

  hsb_regbank #(.NREG(NREG), .BW(BW), .IW(IW)) u_bank (
    .clk(clk), .rst(rst),
    .we(we), .we_hi(we_hi), .widx(widx), .wdata(wdata),
    .ridx(widx), .rword(rword), .flat(regs_o)
  );
endmodule

// File: rtl/hsb_chk.sv
module hsb_chk #(
  parameter int BW    = 8,
  parameter int NBYTE = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          rdy_i,
  input logic          ack_o,
  input logic          ad_oe_o,
  input logic [BW-1:0] addr_q
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!ack_o && !ad_oe_o));

  a_r10_ack_rise_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(rdy_i, 2));

  a_r2_ack_fall_sync: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !$past(rdy_i, 2));

  a_r3_ack_addr_range: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (int'(addr_q) < NBYTE));

  a_r5_drive_before_ack: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_o) && ad_oe_o) |-> $past(ad_oe_o));

  a_r6_release_first: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !$past(ad_oe_o));

  a_r6_oe_drop_under_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(ad_oe_o) |-> ack_o);
endmodule

bind hsbus_regfile hsb_chk #(.BW(BW), .NBYTE(NBYTE)) u_chk (
  .clk(clk), .rst(rst), .rdy_i(rdy_i), .ack_o(ack_o),
  .ad_oe_o(ad_oe_o), .addr_q(addr_q)
);

// File: tb/sim_hsbus_regfile.sv
`timescale 1ns/1ps
module sim_hsbus_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy = 1'b0, hbe = 1'b0, lbe = 1'b0, rd = 1'b0;
  logic [7:0]  adi = 8'h00;
  logic [7:0]  ado;
  logic        oe, ack;
  logic [47:0] regs;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [3];

  always #5 clk = ~clk;

  hsbus_regfile u0 (
    .clk(clk), .rst(rst), .rdy_i(rdy), .hbe_i(hbe), .lbe_i(lbe), .rd_i(rd),
    .ad_i(adi), .ad_o(ado), .ad_oe_o(oe), .ack_o(ack), .regs_o(regs)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one handshake phase; returns whether it was acknowledged
  task automatic phase(input bit h, input bit l, input bit r, input logic [7:0] v,
                       input int hold, output bit acked, output logic [7:0] got,
                       output bit oe_at_ack, output bit rel_ok);
    bit last_oe;
    acked = 0; got = 8'h00; oe_at_ack = 0; rel_ok = 1;
    @(negedge clk);
    hbe = h; lbe = l; rd = r; adi = v;
    @(negedge clk);
    rdy = 1'b1;
    for (int i = 0; i < 12 && !acked; i++) begin
      @(negedge clk);
      if (ack) begin acked = 1; got = ado; oe_at_ack = oe; end
    end
    if (acked) begin
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk("R2 ack held while ready high", {47'd0, ack}, 48'd1);
      end
      rdy = 1'b0;
      last_oe = oe;
      for (int i = 0; i < 12 && ack; i++) begin
        @(negedge clk);
        if (ack) last_oe = oe;
      end
      if (last_oe) rel_ok = 0;
      chk("R2 ack drops after ready low", {47'd0, ack}, 48'd0);
    end else begin
      rdy = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input bit hi, input logic [7:0] v);
    bit k; logic [7:0] g; bit o, ro;
    phase(0, 0, 0, a, 0, k, g, o, ro);
    chk("R2 address acked", {47'd0, k}, 48'd1);
    phase(hi, !hi, 0, v, 0, k, g, o, ro);
    chk("R4 write phase acked", {47'd0, k}, 48'd1);
    chk("R6 no drive on write", {47'd0, o}, 48'd0);
    if (hi) model[a >> 1][15:8] = v; else model[a >> 1][7:0] = v;
    chk("R8 register view", regs, {model[2], model[1], model[0]});
  endtask

  task automatic rd_byte(input logic [7:0] a, input bit hi, input string req);
    bit k; logic [7:0] g; bit o, ro; logic [7:0] e;
    phase(0, 0, 1, a, 0, k, g, o, ro);
    chk("R6 no drive on address", {47'd0, o}, 48'd0);
    phase(hi, !hi, 1, 8'h00, 0, k, g, o, ro);
    e = hi ? model[a >> 1][15:8] : model[a >> 1][7:0];
    chk({req, " read acked"}, {47'd0, k}, 48'd1);
    chk("R5 lane enabled at ack", {47'd0, o}, 48'd1);
    chk({req, " read byte"}, {40'd0, g}, {40'd0, e});
    chk("R6 release before ack falls", {47'd0, ro}, 48'd1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit k; logic [7:0] g; bit o, ro;
    for (int i = 0; i < 3; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ack", {47'd0, ack}, 48'd0);
    chk("R1 reset oe", {47'd0, oe}, 48'd0);
    chk("R1 reset regs", regs, 48'd0);

    // R2: hold ready high and confirm ack stays
    phase(0, 0, 0, 8'h02, 8, k, g, o, ro);
    chk("R2 long hold acked", {47'd0, k}, 48'd1);

    // word writes and reads over all words (R4, R5, R8)
    for (int w = 0; w < 3; w++) begin
      logic [15:0] d;
      d = 16'hA5C3 ^ (16'(w) * 16'h1357);
      wr_byte(8'(2 * w), 1, d[15:8]);
      wr_byte(8'(2 * w), 0, d[7:0]);
    end
    for (int w = 0; w < 3; w++) begin
      rd_byte(8'(2 * w), 1, "R5 high");
      rd_byte(8'(2 * w), 0, "R5 low");
    end

    // R9: odd address reaches the same word; lane picked by enable
    for (int w = 0; w < 3; w++) begin
      wr_byte(8'(2 * w + 1), 0, 8'(8'h10 + w));
      rd_byte(8'(2 * w + 1), 0, "R9 odd low");
      rd_byte(8'(2 * w + 1), 1, "R9 odd high");
      rd_byte(8'(2 * w), 0, "R9 even sees odd write");
    end

    // R3: every out-of-range address ignored, and its data phases too
    for (int a = 6; a < 256; a++) begin
      phase(0, 0, 0, 8'(a), 0, k, g, o, ro);
      if (k) chk("R3 bad address acked", {47'd0, k}, 48'd0);
      checks++;
    end
    phase(1, 0, 0, 8'hEE, 0, k, g, o, ro);
    chk("R3 data after bad address not acked", {47'd0, k}, 48'd0);
    phase(0, 1, 1, 8'h00, 0, k, g, o, ro);
    chk("R3 read after bad address not acked", {47'd0, k}, 48'd0);
    chk("R3 regs unchanged", regs, {model[2], model[1], model[0]});

    // R7: both lanes at once
    phase(0, 0, 0, 8'h04, 0, k, g, o, ro);
    chk("R7 address acked", {47'd0, k}, 48'd1);
    phase(1, 1, 0, 8'h5A, 0, k, g, o, ro);
    chk("R7 dual lane not acked", {47'd0, k}, 48'd0);
    chk("R7 regs unchanged", regs, {model[2], model[1], model[0]});

    // R1: reset in the middle of a driven read
    phase(0, 0, 1, 8'h00, 0, k, g, o, ro);
    @(negedge clk); hbe = 1'b1; rd = 1'b1;
    @(negedge clk); rdy = 1'b1;
    for (int i = 0; i < 12 && !ack; i++) @(negedge clk);
    chk("R5 driving before reset", {47'd0, oe}, 48'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-read ack", {47'd0, ack}, 48'd0);
    chk("R1 mid-read oe", {47'd0, oe}, 48'd0);
    chk("R1 mid-read regs", regs, 48'd0);
    rdy = 1'b0; hbe = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", {46'd0, ack, oe}, 48'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule